// File: doc/BRIEF.md
# Paged External Memory Address Extender

This block sits between a CPU with a 16-bit external address and an external memory with a 21-bit address, giving the CPU a 2 MB physical space. Every external access, whether an instruction fetch or a data read or write, is translated. The top four bits of the logical address select one of sixteen 9-bit page entries. That entry replaces those four bits, and the twelve untouched offset bits are appended below it. Pages are therefore 4 KB, and any logical page can be placed on any of 512 physical page frames.

The translation is purely combinational, so the physical address is valid in the same cycle as the logical address. The page entries are loaded through three special-function-register addresses on a byte-wide write port:
- a selector register picks the entry;
- a staging register holds the entry's top bit;
- a write to the low-data register commits the full entry.

After reset the table is the identity, so the first 64 KB map one-to-one and existing code runs unchanged.

Top module: `mem_page_xlate`

## Requirements
- R1: `mem_addr` equals {entry[`cpu_addr[15:12]`], `cpu_addr[11:0]`} in the same cycle as `cpu_addr`, with the 9-bit entry occupying bits 20:12.
- R2: A synchronous reset sets entry i to the value i, so `mem_addr` equals `cpu_addr` zero-extended to 21 bits until an entry is changed.
- R3: A write with `sfr_we`=1 to address 0xF1 (the selector) stores `sfr_wdata[3:0]` as the entry index. Bits 7:4 are ignored.
- R4: A write to address 0xF2 (the staging register) stores `sfr_wdata[0]` as bit 8 of the next committed entry. Bits 7:1 are ignored.
- R5: A write to address 0xF3 (low data) stores {stage, `sfr_wdata`} into the entry chosen by the selector at the clock edge. Every access from the next cycle onward uses the new value, and all other entries keep their values.
- R6: A cycle with `sfr_we`=0, or a write to any address other than 0xF1, 0xF2 or 0xF3, changes no entry.
- R7: The strobes `cpu_rd`, `cpu_wr` and `cpu_fetch` reach `mem_rd`, `mem_wr` and `mem_fetch` unchanged in the same cycle. Write data passes from `cpu_wdata` to `mem_wdata`, and read data from `mem_rdata` to `cpu_rdata`. Fetches and data accesses translate identically.
- R8: The selector and the staging register keep their values across commits, and reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical external address from the CPU |
| cpu_rd | input | 1 | CPU data read strobe |
| cpu_wr | input | 1 | CPU data write strobe |
| cpu_fetch | input | 1 | CPU program fetch strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| sfr_we | input | 1 | Register write enable |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| mem_addr | output | 21 | Physical address to external memory |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| mem_fetch | output | 1 | Fetch strobe to memory |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 8 | Read data from memory |

## Verification
The hardest case to reach from the ports is a commit that must land in exactly one entry with a ninth bit set by an earlier, separate write. This depends on two pieces of retained state, the selector and the stage, that are never visible directly. The stimulus first loads the stage and the selector, then commits with the low-data write. It then probes every logical page, so that both the target entry and its untouched neighbours appear on `mem_addr`. Ignored bits, foreign register addresses and commits that reuse retained state are all checked the same way, through the translated address of the following access.

// File: rtl/mem_page_pkg.sv
package mem_page_pkg;

    localparam int SFR_DW = 8;

    typedef struct packed {
        logic              sel_idx;
        logic              sel_hi;
        logic              sel_lo;
        logic [SFR_DW-1:0] wdata;
    } sfr_op_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } strobe_t;

    function automatic logic [31:0] pte_reset_value(input int unsigned idx);
        return 32'(idx);
    endfunction

endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
    import mem_page_pkg::*;
#(
    parameter logic [7:0] IDX_ADDR = 8'hF1,
    parameter logic [7:0] HI_ADDR  = 8'hF2,
    parameter logic [7:0] LO_ADDR  = 8'hF3
) (
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [SFR_DW-1:0] wdata,
    output sfr_op_t           op
);
    always_comb begin
        op.sel_idx = we && (addr == IDX_ADDR);
        op.sel_hi  = we && (addr == HI_ADDR);
        op.sel_lo  = we && (addr == LO_ADDR);
        op.wdata   = wdata;
    end
endmodule

// File: rtl/page_table.sv
module page_table
    import mem_page_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ENT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  sfr_op_t          op,
    input  logic [IDX_W-1:0] look_idx,
    output logic [ENT_W-1:0] look_ent
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int HI_W  = ENT_W - SFR_DW;

    logic [IDX_W-1:0] idx_q;
    logic [HI_W-1:0]  stage_q;
    logic [ENT_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            stage_q <= '0;
        end else begin
            if (op.sel_idx) idx_q   <= op.wdata[IDX_W-1:0];
            if (op.sel_hi)  stage_q <= op.wdata[HI_W-1:0];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [ENT_W-1:0] RST_V = ENT_W'(pte_reset_value(i));
        always_ff @(posedge clk) begin
            if (rst)
                tbl[i] <= RST_V;
            else if (op.sel_lo && idx_q == IDX_W'(i))
                tbl[i] <= {stage_q, op.wdata};
        end

        // R5: a commit aimed at this entry shows up on the next cycle
        p_commit_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(op.sel_lo) && $past(idx_q) == IDX_W'(i))
            |-> tbl[i] == {$past(stage_q), $past(op.wdata)});

        // R6: entries not targeted by a commit hold
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !($past(op.sel_lo) && $past(idx_q) == IDX_W'(i)))
            |-> $stable(tbl[i]));
    end

    assign look_ent = tbl[look_idx];

    // R3: selector takes the low bits of a selector write
    p_index_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op.sel_idx))
        |-> idx_q == $past(op.wdata[IDX_W-1:0]));

    // R8: selector and stage persist when their registers are not written
    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op.sel_idx) && !$past(op.sel_hi))
        |-> ($stable(idx_q) && $stable(stage_q)));

    // R4: stage takes bit 0 of a staging write
    p_stage_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op.sel_hi))
        |-> stage_q == $past(op.wdata[HI_W-1:0]));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
    parameter int LADDR_W = 16,
    parameter int IDX_W   = 4,
    parameter int PADDR_W = 21
) (
    input  logic [LADDR_W-1:0]         laddr,
    input  logic [PADDR_W-LADDR_W+IDX_W-1:0] entry,
    output logic [IDX_W-1:0]           page,
    output logic [PADDR_W-1:0]         paddr
);
    localparam int OFF_W = LADDR_W - IDX_W;

    always_comb begin
        page  = laddr[LADDR_W-1:OFF_W];
        paddr = {entry, laddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/mem_page_xlate.sv
module mem_page_xlate
    import mem_page_pkg::*;
#(
    parameter int         LADDR_W  = 16,
    parameter int         PADDR_W  = 21,
    parameter int         IDX_W    = 4,
    parameter logic [7:0] IDX_ADDR = 8'hF1,
    parameter logic [7:0] HI_ADDR  = 8'hF2,
    parameter logic [7:0] LO_ADDR  = 8'hF3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LADDR_W-1:0] cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic               cpu_fetch,
    input  logic [SFR_DW-1:0]  cpu_wdata,
    output logic [SFR_DW-1:0]  cpu_rdata,
    input  logic               sfr_we,
    input  logic [7:0]         sfr_addr,
    input  logic [SFR_DW-1:0]  sfr_wdata,
    output logic [PADDR_W-1:0] mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_fetch,
    output logic [SFR_DW-1:0]  mem_wdata,
    input  logic [SFR_DW-1:0]  mem_rdata
);
    localparam int OFF_W = LADDR_W - IDX_W;
    localparam int ENT_W = PADDR_W - OFF_W;

    sfr_op_t          op;
    strobe_t          strb;
    logic [IDX_W-1:0] page;
    logic [ENT_W-1:0] entry;

    sfr_decode #(
        .IDX_ADDR(IDX_ADDR), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
    ) u_dec (
        .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata), .op(op)
    );

    page_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
        .clk(clk), .rst(rst), .op(op), .look_idx(page), .look_ent(entry)
    );

    addr_xlate #(.LADDR_W(LADDR_W), .IDX_W(IDX_W), .PADDR_W(PADDR_W)) u_xl (
        .laddr(cpu_addr), .entry(entry), .page(page), .paddr(mem_addr)
    );

    always_comb begin
        strb      = '{rd: cpu_rd, wr: cpu_wr, fetch: cpu_fetch};
        mem_rd    = strb.rd;
        mem_wr    = strb.wr;
        mem_fetch = strb.fetch;
        mem_wdata = cpu_wdata;
        cpu_rdata = mem_rdata;
    end

    // R2: right after reset the mapping is the identity
    p_reset_map_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mem_addr == PADDR_W'(cpu_addr));

    // R1: with no commit and a steady logical address the physical one holds
    p_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op.sel_lo) && $stable(cpu_addr))
        |-> $stable(mem_addr));
endmodule

// File: tb/tb_mem_page_xlate.sv
`timescale 1ns/1ps
module tb_mem_page_xlate;

    typedef struct {
        logic [20:0] addr;
        logic        rd, wr, fetch;
        logic [7:0]  wdata, rdata;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 0, cpu_wr = 0, cpu_fetch = 0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic        sfr_we = 0;
    logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
    logic [20:0] mem_addr;
    logic        mem_rd, mem_wr, mem_fetch;
    logic [7:0]  mem_wdata, mem_rdata = '0;

    always #2.5 clk = ~clk;

    mem_page_xlate dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_fetch(cpu_fetch), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_fetch(mem_fetch), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [8:0] mdl [16];
    logic [3:0] m_idx;
    logic       m_stage;
    exp_t       q[$];
    event       ev_push;
    int         n_vec = 0, n_bad = 0;
    bit         done = 0;

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) mdl[i] = 9'(i);
        m_idx   = '0;
        m_stage = 1'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic sfr_wr(input logic we, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = we; sfr_addr = a; sfr_wdata = d;
        if (we) begin
            if (a == 8'hF1) m_idx = d[3:0];
            else if (a == 8'hF2) m_stage = d[0];
            else if (a == 8'hF3) mdl[m_idx] = {m_stage, d};
        end
        @(negedge clk);
        sfr_we = 0; sfr_addr = '0; sfr_wdata = '0;
    endtask

    task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                          input logic fe, input logic [7:0] wd, input logic [7:0] rdd,
                          input string tag);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_fetch = fe;
        cpu_wdata = wd; mem_rdata = rdd;
        e.addr = {mdl[a[15:12]], a[11:0]};
        e.rd = rd; e.wr = wr; e.fetch = fe; e.wdata = wd; e.rdata = rdd; e.tag = tag;
        q.push_back(e);
        -> ev_push;
    endtask

    // monitor: compares each queued item against the ports 1 ns after drive
    initial begin
        forever begin
            @(ev_push);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (mem_addr !== e.addr || mem_rd !== e.rd || mem_wr !== e.wr ||
                    mem_fetch !== e.fetch || mem_wdata !== e.wdata ||
                    cpu_rdata !== e.rdata) begin
                    n_bad++;
                    $display("FAIL %s: addr %h exp %h, rd/wr/fe %b%b%b exp %b%b%b, wdata %h exp %h, rdata %h exp %h",
                             e.tag, mem_addr, e.addr, mem_rd, mem_wr, mem_fetch,
                             e.rd, e.wr, e.fetch, mem_wdata, e.wdata, cpu_rdata, e.rdata);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R2: identity map after reset, every page
        for (int p = 0; p < 16; p++)
            access(16'(p << 12) | 16'h0ABC, 1, 0, 0, 8'h00, 8'h5A, "R2 identity");
        access(16'hFFFF, 0, 0, 1, 8'h00, 8'h11, "R2 top address");

        // R5: commit with stage bit, effective next access
        sfr_wr(1, 8'hF1, 8'h03);
        sfr_wr(1, 8'hF2, 8'h01);
        sfr_wr(1, 8'hF3, 8'h45);
        access(16'h3123, 1, 0, 0, 8'h00, 8'h77, "R5 commit entry3");
        access(16'h2FFF, 1, 0, 0, 8'h00, 8'h77, "R5 neighbour entry2");
        access(16'h4000, 1, 0, 0, 8'h00, 8'h77, "R5 neighbour entry4");

        // R8: stage and selector retained; recommit reuses both
        sfr_wr(1, 8'hF3, 8'h9C);
        access(16'h3001, 0, 0, 1, 8'h00, 8'h00, "R8 selector retained");
        sfr_wr(1, 8'hF1, 8'h04);
        sfr_wr(1, 8'hF3, 8'h00);
        access(16'h4000, 1, 0, 0, 8'h00, 8'h00, "R8 stage retained");

        // R4: only bit 0 of the staging write matters
        sfr_wr(1, 8'hF2, 8'hFE);
        sfr_wr(1, 8'hF1, 8'h05);
        sfr_wr(1, 8'hF3, 8'hFF);
        access(16'h5ABC, 1, 0, 0, 8'h00, 8'h00, "R4 stage bit0 clear");
        sfr_wr(1, 8'hF2, 8'hFF);
        sfr_wr(1, 8'hF1, 8'h0F);
        sfr_wr(1, 8'hF3, 8'hFF);
        access(16'hFFFF, 1, 0, 0, 8'h00, 8'h00, "R4 max physical address");

        // R3: upper selector bits ignored
        sfr_wr(1, 8'hF1, 8'hA7);
        sfr_wr(1, 8'hF3, 8'h22);
        access(16'h7001, 1, 0, 0, 8'h00, 8'h00, "R3 selector low nibble");
        access(16'hA001, 1, 0, 0, 8'h00, 8'h00, "R3 entry10 untouched");

        // R6: disabled writes and foreign addresses change nothing
        sfr_wr(0, 8'hF3, 8'h00);
        sfr_wr(1, 8'h80, 8'h00);
        sfr_wr(1, 8'hF0, 8'h00);
        sfr_wr(1, 8'hF4, 8'h00);
        access(16'h7123, 1, 0, 0, 8'h00, 8'h00, "R6 entry7 kept");
        access(16'h3123, 1, 0, 0, 8'h00, 8'h00, "R6 entry3 kept");
        sfr_wr(1, 8'hF3, 8'h10);
        access(16'h7123, 1, 0, 0, 8'h00, 8'h00, "R6 stage and selector kept");

        // R7: strobes and data pass through; fetch and data translate alike
        access(16'hF800, 0, 1, 0, 8'hA5, 8'h3C, "R7 write path");
        access(16'hF800, 0, 0, 1, 8'h5A, 8'hC3, "R7 fetch path");
        access(16'hF800, 1, 0, 0, 8'h00, 8'hE7, "R7 read path");
        access(16'h1234, 0, 0, 0, 8'hFF, 8'h01, "R7 idle");

        // R1: remap every page and sweep offsets
        for (int p = 0; p < 16; p++) begin
            sfr_wr(1, 8'hF1, 8'(p));
            sfr_wr(1, 8'hF2, 8'(p & 1));
            sfr_wr(1, 8'hF3, 8'(8'hE1 ^ 8'(p * 37)));
        end
        for (int p = 0; p < 16; p++) begin
            access(16'(p << 12), 1, 0, 0, 8'h00, 8'h00, "R1 page base");
            access(16'(p << 12) | 16'h0FFF, 0, 0, 1, 8'h00, 8'h00, "R1 page end");
        end

        // R8 / R2: reset restores identity and clears selector and stage
        do_reset();
        access(16'hC0DE, 1, 0, 0, 8'h00, 8'h00, "R2 identity after reset");
        sfr_wr(1, 8'hF3, 8'h33);
        access(16'h0456, 1, 0, 0, 8'h00, 8'h00, "R8 reset cleared selector and stage");
        access(16'h1456, 1, 0, 0, 8'h00, 8'h00, "R8 entry1 identity");

        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule